// File: doc/BRIEF.md
# Configurable GPIO function multiplexer

This block manages a bank of general-purpose pins. Each pin has its own byte-wide function code. The code turns the pin into one of several things: an input with a pull-up, an input with a pull-down, an open-drain output of a software level, an open-drain interrupt line, or a push-pull copy of an internal status signal. Any other code leaves the pin as a floating input. For every pin the block drives output-enable, output value and pull-up/pull-down controls towards a pad model. It also returns the pad input levels through a synchronizer.

Software sets the codes and the level bits through a simple register port. A write happens on a clock edge when `reg_we` is high. A read is combinational from `reg_addr`. By convention pin 6 is the pin that carries the interrupt to the host. Any pin can be given the interrupt code, though.

Top module: `gpio_func_mux`

## Requirements
- R1: After reset every function code and every level bit reads 0. `pad_oe`, `pad_out`, `pad_pu` and `pad_pd` are all 0.
- R2: Code 0x01 sets only the pull-up of that pin, and code 0x02 sets only the pull-down. In both cases output-enable stays 0.
- R3: Code 0x03 is an active-high open-drain output. The pin's output-enable is the inverse of its level bit.
- R4: Code 0x04 is an active-low open-drain output. The pin's output-enable equals its level bit. In every open-drain mode `pad_out` stays 0.
- R5: Code 0x05 is an open-drain interrupt output. Output-enable follows `irq_active`, and `pad_out` is 0.
- R6: The status codes drive the pin push-pull. Output-enable is 1 and `pad_out` follows the selected signal: 0x06 selects `fw_ready`, 0x1A selects `pwr_xfer`, and 0x1E selects `tx_fault`.
- R7: Any other code (for example 0x00, 0x07, 0x1B, 0xFF) leaves the pin with no pull and no drive.
- R8: Register addresses are as follows. Address i (0 to NPINS-1) holds pin i's code. Address NPINS holds the level bits, where bit i is pin i. Address NPINS+1 reads the synchronized input levels. Every other address reads 0.
- R9: Writes to address NPINS+1, and to addresses above it, change no code and no level bit.
- R10: A change on `pad_in` reaches `pin_level` and the input register after SYNC_STAGES rising clock edges, and not earlier.
- R11: A code write to one pin changes no other pin's code or pad controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq_active | input | 1 | High while any enabled interrupt is latched |
| fw_ready | input | 1 | Firmware-ready status |
| pwr_xfer | input | 1 | Power transfer in progress |
| tx_fault | input | 1 | Transmitter in its stopping error state |
| pad_in | input | NPINS | Raw pad input levels |
| pad_oe | output | NPINS | Pad output enable |
| pad_out | output | NPINS | Pad output value |
| pad_pu | output | NPINS | Pull-up enable |
| pad_pd | output | NPINS | Pull-down enable |
| pin_level | output | NPINS | Synchronized input levels |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchronizer. With eight pins the register map runs through address 9, so the level register, the read-only input register and the unmapped addresses above them are all reachable with a 4-bit address. With two stages, the bench can show the cycle on which an input edge must not yet be visible and the cycle on which it must be. Each code is placed on a different pin, so that cross-talk between pins would show.

// File: rtl/gpio_func_mux.sv
module gpio_func_mux #(
  parameter int NPINS = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(NPINS + 2),
  localparam int DATA_W = (NPINS > 8) ? NPINS : 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_active,
  input  logic              fw_ready,
  input  logic              pwr_xfer,
  input  logic              tx_fault,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd,
  output logic [NPINS-1:0]  pin_level
);
  localparam logic [7:0] F_PULLUP = 8'h01;
  localparam logic [7:0] F_PULLDN = 8'h02;
  localparam logic [7:0] F_OD_HI  = 8'h03;
  localparam logic [7:0] F_OD_LO  = 8'h04;
  localparam logic [7:0] F_IRQ    = 8'h05;
  localparam logic [7:0] F_FWRDY  = 8'h06;
  localparam logic [7:0] F_PWR    = 8'h1A;
  localparam logic [7:0] F_FAULT  = 8'h1E;
  localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(NPINS + 1);

  logic [NPINS-1:0][7:0]             code_q;
  logic [NPINS-1:0]                  lvl_q;
  logic [SYNC_STAGES-1:0][NPINS-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      lvl_q  <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < NPINS; i++)
        if (reg_addr == ADDR_W'(i)) code_q[i] <= reg_wdata[7:0];
      if (reg_addr == A_LVL) lvl_q <= reg_wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else begin
      sync_q[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign pin_level = sync_q[SYNC_STAGES-1];

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NPINS; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = DATA_W'(code_q[i]);
    if (reg_addr == A_LVL) reg_rdata = DATA_W'(lvl_q);
    if (reg_addr == A_IN)  reg_rdata = DATA_W'(pin_level);
  end

  always_comb begin
    pad_oe  = '0;
    pad_out = '0;
    pad_pu  = '0;
    pad_pd  = '0;
    for (int i = 0; i < NPINS; i++) begin
      case (code_q[i])
        F_PULLUP: pad_pu[i] = 1'b1;
        F_PULLDN: pad_pd[i] = 1'b1;
        F_OD_HI:  pad_oe[i] = ~lvl_q[i];
        F_OD_LO:  pad_oe[i] = lvl_q[i];
        F_IRQ:    pad_oe[i] = irq_active;
        F_FWRDY:  begin pad_oe[i] = 1'b1; pad_out[i] = fw_ready; end
        F_PWR:    begin pad_oe[i] = 1'b1; pad_out[i] = pwr_xfer; end
        F_FAULT:  begin pad_oe[i] = 1'b1; pad_out[i] = tx_fault; end
        default:  ;
      endcase
    end
  end
endmodule

module gpio_func_mux_chk #(
  parameter int NPINS = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [DATA_W-1:0]     reg_wdata,
  input logic                  irq_active,
  input logic [NPINS-1:0]      pad_oe,
  input logic [NPINS-1:0]      pad_out,
  input logic [NPINS-1:0]      pad_pu,
  input logic [NPINS-1:0]      pad_pd,
  input logic [NPINS-1:0][7:0] code_q,
  input logic [NPINS-1:0]      lvl_q
);
  a_r4_out_only_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  a_r2_pull_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == '0) && (((pad_pu | pad_pd) & pad_oe) == '0));

  a_r9_readonly_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr > ADDR_W'(NPINS)) |=> ($stable(code_q) && $stable(lvl_q)));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    a_r11_code_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(i)) |=> (code_q[i] == $past(reg_wdata[7:0])));

    a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q[i] == 8'h05) |-> (pad_oe[i] == irq_active && !pad_out[i]));
  end
endmodule

bind gpio_func_mux gpio_func_mux_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_gpio_func_mux.sv
`timescale 1ns/1ps
module test_gpio_func_mux;
  localparam int NPINS = 8;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic irq_active = 0, fw_ready = 0, pwr_xfer = 0, tx_fault = 0;
  logic [NPINS-1:0] pad_in = '0, pad_oe, pad_out, pad_pu, pad_pd, pin_level;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  gpio_func_mux i_gpio_func_mux (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 0;
    #1;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic clear_all();
    for (int i = 0; i < NPINS; i++) wr(i, 0);
    wr(NPINS, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 out", 32'(pad_out), 0);
    chk("R1 pu|pd", 32'(pad_pu | pad_pd), 0);
    for (int i = 0; i <= NPINS; i++) rd_chk("R1 reg", i, 0);
  endtask

  task automatic t_pulls();
    wr(0, 8'h01); wr(1, 8'h02);
    chk("R2 pu", 32'(pad_pu), 32'h01);
    chk("R2 pd", 32'(pad_pd), 32'h02);
    chk("R2 oe", 32'(pad_oe), 0);
    clear_all();
  endtask

  task automatic t_open_drain();
    wr(2, 8'h03); wr(3, 8'h04);
    chk("R3 lvl0 oe", 32'(pad_oe), 32'h04);
    wr(NPINS, 8'h0C);
    chk("R4 lvl1 oe", 32'(pad_oe), 32'h08);
    chk("R4 out zero", 32'(pad_out), 0);
    wr(NPINS, 8'h04);
    chk("R3 lvl mix oe", 32'(pad_oe), 32'h00);
    clear_all();
  endtask

  task automatic t_irq();
    wr(6, 8'h05);
    chk("R5 idle", 32'(pad_oe), 0);
    @(negedge clk); irq_active = 1; #1;
    chk("R5 active oe", 32'(pad_oe), 32'h40);
    chk("R5 active out", 32'(pad_out), 0);
    @(negedge clk); irq_active = 0; #1;
    chk("R5 release", 32'(pad_oe), 0);
    clear_all();
  endtask

  task automatic t_status();
    wr(4, 8'h06); wr(5, 8'h1A); wr(7, 8'h1E);
    chk("R6 oe", 32'(pad_oe), 32'hB0);
    chk("R6 all low", 32'(pad_out), 0);
    @(negedge clk); fw_ready = 1; #1;
    chk("R6 fw", 32'(pad_out), 32'h10);
    @(negedge clk); fw_ready = 0; pwr_xfer = 1; #1;
    chk("R6 pwr", 32'(pad_out), 32'h20);
    @(negedge clk); pwr_xfer = 0; tx_fault = 1; #1;
    chk("R6 fault", 32'(pad_out), 32'h80);
    @(negedge clk); tx_fault = 0;
    clear_all();
  endtask

  task automatic t_unlisted();
    @(negedge clk); irq_active = 1; fw_ready = 1; pwr_xfer = 1; tx_fault = 1;
    wr(NPINS, 8'hFF);
    wr(0, 8'h07);
    chk("R7 0x07", 32'(pad_oe | pad_out | pad_pu | pad_pd), 0);
    wr(0, 8'h1B);
    chk("R7 0x1B", 32'(pad_oe | pad_out | pad_pu | pad_pd), 0);
    wr(0, 8'hFF);
    chk("R7 0xFF", 32'(pad_oe | pad_out | pad_pu | pad_pd), 0);
    @(negedge clk); irq_active = 0; fw_ready = 0; pwr_xfer = 0; tx_fault = 0;
    clear_all();
  endtask

  task automatic t_regs();
    for (int i = 0; i < NPINS; i++) wr(i, 8'h10 + i);
    wr(NPINS, 8'hA5);
    for (int i = 0; i < NPINS; i++) rd_chk("R8 code", i, 8'h10 + i);
    rd_chk("R8 lvl", NPINS, 8'hA5);
    rd_chk("R8 unmapped", 12, 0);
    wr(NPINS + 1, 8'h3C);
    wr(15, 8'h5A);
    for (int i = 0; i < NPINS; i++) rd_chk("R9 code kept", i, 8'h10 + i);
    rd_chk("R9 lvl kept", NPINS, 8'hA5);
    clear_all();
  endtask

  task automatic t_independent();
    wr(1, 8'h01); wr(5, 8'h02);
    wr(3, 8'h06);
    rd_chk("R11 pin1", 1, 8'h01);
    rd_chk("R11 pin5", 5, 8'h02);
    chk("R11 pu", 32'(pad_pu), 32'h02);
    chk("R11 pd", 32'(pad_pd), 32'h20);
    clear_all();
  endtask

  task automatic t_sync();
    @(negedge clk); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h69;
    @(negedge clk); #1;
    chk("R10 one edge", 32'(pin_level), 0);
    @(negedge clk); #1;
    chk("R10 two edges", 32'(pin_level), 32'h69);
    rd_chk("R10 reg", NPINS + 1, 8'h69);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_pulls();
    t_open_drain();
    t_irq();
    t_status();
    t_unlisted();
    t_regs();
    t_independent();
    t_sync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule